// File: doc/BRIEF.md
# Ownership-Flagged Event Queue Writer

This block stores event status words in a circular queue kept in shared memory. A slot belongs to the writer while its top bit (bit 15, the new-status flag) is 0 and to the host while that bit is 1. The host hands a slot back by clearing the bit. The block never tracks a host read pointer. Before each store it reads the target slot and checks the flag itself.

An event is a three-bit source code plus a six-bit payload. The block takes it through a valid/ready handshake into a one-entry holding register. It then runs a read, check and write sequence on a simple memory port, where read data returns one cycle after a read strobe. If the slot is free, the packed word is written back to the same address and the pointer moves on. If the slot is busy, nothing is written and a sticky overflow flag is raised. The queue's base address and length are configuration inputs. They are held constant while the block is out of reset.

Top module: `evq_writer`

## Requirements
- R1: After reset `ev_ready` is 1, `mem_rd`, `mem_wr` and `ovf_flag` are 0, and the first memory access made after reset addresses `cfg_base`.
- R2: Every accepted event with a non-reserved source causes exactly one read strobe to the current slot address, and the read data is examined in the following cycle.
- R3: When the slot read has bit 15 equal to 0, the block writes to that address the word with bit 15 = 1, bit 14 = 0, bits 13:11 = source code, bits 10:6 = 0 and bits 5:0 = payload.
- R4: When the slot read has bit 15 equal to 1, no write is made and `ovf_flag` becomes 1 in the next cycle.
- R5: `ovf_flag` stays 1 until a cycle in which `ovf_clr` is 1, and it then reads 0 from the following cycle on.
- R6: The slot address advances by one after each store and wraps from `cfg_base + cfg_size - 1` back to `cfg_base`, modulo the address width. Every access lies inside that window.
- R7: After an overflow the pointer does not move. The next event targets the same slot.
- R8: Events whose source code is 110 or 111 are consumed without any memory access and without any effect on the pointer or on `ovf_flag`.
- R9: `ev_ready` is 0 while the holding register is occupied. Accepted events are handled in acceptance order and none is lost.
- R10: `mem_rd` and `mem_wr` are never 1 together, and a write always goes to the address read in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_base | input | ADDR_W | First word address of the queue |
| cfg_size | input | ADDR_W+1 | Number of slots in the queue (at least 1) |
| ev_valid | input | 1 | Event request present |
| ev_ready | output | 1 | Holding register free, request accepted when valid |
| ev_src | input | 3 | Event source code |
| ev_payload | input | 6 | Six payload bits of the event |
| mem_rd | output | 1 | Read strobe, data returned on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Slot address for read and write |
| mem_wdata | output | 16 | Packed status word |
| mem_rdata | input | 16 | Slot contents, valid the cycle after `mem_rd` |
| ovf_flag | output | 1 | Sticky queue-overflow flag |
| ovf_clr | input | 1 | Clears `ovf_flag` |

## Verification
A pointer that slips by one shows up as a misplaced status word. The bench detects it at the end of the batch that exposes it, by comparing all memory words with a model. A wrong wrap limit shows up the same way, and so does a pointer that moves on overflow, because host-cleared slots are then refilled in the wrong place. A corrupted ownership decision shows up in the next cycle. Either a word is overwritten while its flag is set, or an overflow is raised without a busy slot. The bind checker catches this at once, and the bench catches it through the write count and the flag. A holding register that drops or duplicates an event changes the read and write counts of the same batch.

// File: rtl/evq_pkg.sv
package evq_pkg;

   localparam int WORD_W  = 16;
   localparam int SRC_W   = 3;
   localparam int PAY_W   = 6;
   localparam int NS_BIT  = 15;
   localparam int SRC_LSB = 11;

   typedef enum logic [SRC_W-1:0] {
      SRC_PRIM_M0  = 3'b000,
      SRC_PRIM_M1  = 3'b001,
      SRC_SWB_M0   = 3'b010,
      SRC_SWB_M1   = 3'b011,
      SRC_ALARM_M0 = 3'b100,
      SRC_ALARM_M1 = 3'b101,
      SRC_RSV_A    = 3'b110,
      SRC_RSV_B    = 3'b111
   } evq_src_e;

   typedef struct packed {
      logic [SRC_W-1:0] src;
      logic [PAY_W-1:0] pay;
   } evq_event_t;

   function automatic logic evq_is_reserved(input logic [SRC_W-1:0] src);
      return src[SRC_W-1:SRC_W-2] == 2'b11;
   endfunction

   function automatic logic [WORD_W-1:0] evq_pack(input evq_event_t ev);
      logic [WORD_W-1:0] w;
      w = '0;
      w[NS_BIT] = 1'b1;
      w[SRC_LSB +: SRC_W] = ev.src;
      w[PAY_W-1:0] = ev.pay;
      return w;
   endfunction

endpackage

// File: rtl/evq_hold.sv
module evq_hold
   import evq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  evq_event_t in_ev,
   input  logic       pop,
   output logic       out_valid,
   output evq_event_t out_ev
);

   logic       full_q;
   evq_event_t data_q;

   assign in_ready  = !full_q;
   assign out_valid = full_q;
   assign out_ev    = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (in_valid && !full_q) begin
         full_q <= 1'b1;
         data_q <= in_ev;
      end else if (pop) begin
         full_q <= 1'b0;
      end
   end

endmodule

// File: rtl/evq_ptr.sv
module evq_ptr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W:0]   cfg_size,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr
);

   localparam int CNT_W = ADDR_W + 1;

   logic [ADDR_W-1:0] off_q;
   logic [CNT_W-1:0]  off_inc;
   logic              wrap;

   assign off_inc = {1'b0, off_q} + CNT_W'(1);
   assign wrap    = off_inc >= cfg_size;
   assign addr    = cfg_base + off_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         off_q <= '0;
      else if (advance)
         off_q <= wrap ? '0 : off_inc[ADDR_W-1:0];
   end

endmodule

// File: rtl/evq_seq.sv
module evq_seq
   import evq_pkg::*;
#(
   parameter bit BACK_TO_BACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_valid,
   input  evq_event_t        hold_ev,
   output logic              pop,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              slot_busy,
   output logic              advance,
   output logic              ovf_set
);

   typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CHECK} st_e;

   st_e        st_q, st_nx;
   evq_event_t cur_q;
   logic       load;
   logic       chain_ok;

   generate
      if (BACK_TO_BACK) begin : g_chain
         assign chain_ok = hold_valid && !evq_is_reserved(hold_ev.src);
      end else begin : g_no_chain
         assign chain_ok = 1'b0;
      end
   endgenerate

   assign mem_wdata = evq_pack(cur_q);

   always_comb begin
      st_nx   = st_q;
      pop     = 1'b0;
      load    = 1'b0;
      mem_rd  = 1'b0;
      mem_wr  = 1'b0;
      advance = 1'b0;
      ovf_set = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (hold_valid) begin
               pop = 1'b1;
               if (!evq_is_reserved(hold_ev.src)) begin
                  load  = 1'b1;
                  st_nx = ST_READ;
               end
            end
         end
         ST_READ: begin
            mem_rd = 1'b1;
            st_nx  = ST_CHECK;
         end
         ST_CHECK: begin
            if (slot_busy) begin
               ovf_set = 1'b1;
            end else begin
               mem_wr  = 1'b1;
               advance = 1'b1;
            end
            st_nx = ST_IDLE;
            if (chain_ok) begin
               pop   = 1'b1;
               load  = 1'b1;
               st_nx = ST_READ;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cur_q <= '0;
      end else begin
         st_q <= st_nx;
         if (load)
            cur_q <= hold_ev;
      end
   end

endmodule

// File: rtl/evq_writer.sv
module evq_writer
   import evq_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter bit BACK_TO_BACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W:0]   cfg_size,
   input  logic              ev_valid,
   output logic              ev_ready,
   input  logic [SRC_W-1:0]  ev_src,
   input  logic [PAY_W-1:0]  ev_payload,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              ovf_flag,
   input  logic              ovf_clr
);

   generate
      if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_addr_w
         $error("evq_writer: ADDR_W must lie in 2..24");
      end
   endgenerate

   evq_event_t in_ev, hold_ev;
   logic       hold_valid, pop, advance, ovf_set;
   logic       ovf_q;
   logic       unused_rdata;

   assign in_ev        = '{src: ev_src, pay: ev_payload};
   assign unused_rdata = ^mem_rdata[NS_BIT-1:0];
   assign ovf_flag     = ovf_q;

   evq_hold u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (ev_valid),
      .in_ready  (ev_ready),
      .in_ev     (in_ev),
      .pop       (pop),
      .out_valid (hold_valid),
      .out_ev    (hold_ev)
   );

   evq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_base (cfg_base),
      .cfg_size (cfg_size),
      .advance  (advance),
      .addr     (mem_addr)
   );

   evq_seq #(.BACK_TO_BACK(BACK_TO_BACK)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_valid (hold_valid),
      .hold_ev    (hold_ev),
      .pop        (pop),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_wdata  (mem_wdata),
      .slot_busy  (mem_rdata[NS_BIT]),
      .advance    (advance),
      .ovf_set    (ovf_set)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (ovf_set)
         ovf_q <= 1'b1;
      else if (ovf_clr)
         ovf_q <= 1'b0;
   end

endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cfg_base,
   input logic [ADDR_W:0]   cfg_size,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [15:0]       mem_wdata,
   input logic [15:0]       mem_rdata,
   input logic              ovf_flag,
   input logic              ovf_clr
);

   logic [ADDR_W-1:0] rel_addr;
   assign rel_addr = mem_addr - cfg_base;

   assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd) && $stable(mem_addr)));

   assert_wr_free_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (!mem_rdata[15] && mem_wdata[15] && !mem_wdata[14]));

   assert_busy_sets_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_rd) && mem_rdata[15]) |=> ovf_flag);

   assert_busy_no_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_rd) && mem_rdata[15]) |-> !mem_wr);

   assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_rd) && mem_rdata[15]) |=> $stable(mem_addr));

   assert_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && cfg_size != '0) |-> ({1'b0, rel_addr} < cfg_size));

endmodule

bind evq_writer evq_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_base  (cfg_base),
   .cfg_size  (cfg_size),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata),
   .ovf_flag  (ovf_flag),
   .ovf_clr   (ovf_clr)
);

// File: tb/test_evq_writer.sv
module test_evq_writer;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic [AW:0]   cfg_size = 5'd1;
   logic          ev_valid = 1'b0;
   logic          ev_ready;
   logic [2:0]    ev_src = '0;
   logic [5:0]    ev_payload = '0;
   logic          mem_rd, mem_wr;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_wdata;
   logic [15:0]   mem_rdata;
   logic          ovf_flag;
   logic          ovf_clr = 1'b0;

   logic          host_we = 1'b0;
   logic [AW-1:0] host_a = '0;
   logic [15:0]   host_d = '0;

   logic [15:0] ram [NW];
   int          rd_cnt, wr_cnt;
   logic        first_seen, both_seen;
   logic [AW-1:0] first_addr;

   logic [15:0] mdl [NW];
   int  mptr, msize, mbase;
   bit  movf;
   int  checks = 0, errors = 0;
   bit  saw_not_ready = 0;
   bit  done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evq_writer #(.ADDR_W(AW)) i_evq_writer (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_src(ev_src), .ev_payload(ev_payload),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
   );

   // shared memory model with one-cycle read latency
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) ram[i] <= '0;
         rd_cnt <= 0; wr_cnt <= 0;
         first_seen <= 1'b0; both_seen <= 1'b0; first_addr <= '0;
         mem_rdata <= '0;
      end else begin
         if (host_we) ram[host_a] <= host_d;
         if (mem_wr) begin ram[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
         if (mem_rd) begin mem_rdata <= ram[mem_addr]; rd_cnt <= rd_cnt + 1; end
         if (mem_rd && mem_wr) both_seen <= 1'b1;
         if ((mem_rd || mem_wr) && !first_seen) begin
            first_seen <= 1'b1; first_addr <= mem_addr;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic do_reset(input int base, input int size);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_base = AW'(base);
      cfg_size = (AW+1)'(size);
      mbase = base; msize = size; mptr = 0; movf = 0;
      for (int i = 0; i < NW; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [15:0] word_of(input int src, input int pay);
      return 16'((1 << 15) | (src << 11) | (pay & 63));
   endfunction

   task automatic model_event(input int src, input int pay);
      int a;
      if (src >= 6) return;
      a = (mbase + mptr) % NW;
      if (mdl[a][15]) movf = 1;
      else begin
         mdl[a] = word_of(src, pay);
         mptr = (mptr + 1) % msize;
      end
   endtask

   task automatic send(input int src, input int pay);
      @(negedge clk);
      ev_valid = 1'b1; ev_src = 3'(src); ev_payload = 6'(pay);
      while (!ev_ready) begin saw_not_ready = 1; @(negedge clk); end
      @(posedge clk);
      model_event(src, pay);
      #1 ev_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (10) @(negedge clk);
   endtask

   task automatic host_release(input int a);
      @(negedge clk);
      host_we = 1'b1; host_a = AW'(a); host_d = ram[a] & 16'h7FFF;
      mdl[a][15] = 1'b0;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      movf = 0;
   endtask

   task automatic cmp_mem(input string req);
      int mis = 0, fa = 0;
      for (int i = 0; i < NW; i++)
         if (ram[i] !== mdl[i]) begin if (mis == 0) fa = i; mis++; end
      chk(mis == 0, req, $sformatf("memory word %0d", fa), int'(ram[fa]), int'(mdl[fa]));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end

   initial begin
      int bases[3] = '{0, 5, 13};
      int sizes[5] = '{1, 2, 3, 4, 7};

      // R1 reset state
      do_reset(3, 4);
      @(negedge clk);
      chk(ev_ready === 1'b1, "R1", "ev_ready after reset", int'(ev_ready), 1);
      chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R1", "strobes after reset", int'({mem_rd, mem_wr}), 0);
      chk(ovf_flag === 1'b0, "R1", "ovf after reset", int'(ovf_flag), 0);
      send(2, 9);
      settle();
      chk(first_addr == 4'd3, "R1", "first access address", int'(first_addr), 3);
      chk(ram[3] == word_of(2, 9), "R3", "packed word", int'(ram[3]), int'(word_of(2, 9)));

      // sweep over base and size: fill, overflow, release, refill
      foreach (bases[b]) foreach (sizes[s]) begin
         int base = bases[b];
         int size = sizes[s];
         do_reset(base, size);
         for (int k = 0; k < size + 2; k++) send(k % 6, (k * 11 + base) & 63);
         settle();
         cmp_mem("R3/R6");
         chk(rd_cnt == size + 2, "R2", "read count", rd_cnt, size + 2);
         chk(wr_cnt == size, "R6", "write count", wr_cnt, size);
         chk(ovf_flag === movf, "R4", "ovf after full queue", int'(ovf_flag), int'(movf));
         repeat (20) @(negedge clk);
         chk(ovf_flag === 1'b1, "R5", "ovf sticky", int'(ovf_flag), 1);
         pulse_clr();
         chk(ovf_flag === 1'b0, "R5", "ovf cleared", int'(ovf_flag), 0);
         if (size > 1) begin
            host_release((base + 1) % NW);
            send(5, 33);
            settle();
            chk(ovf_flag === 1'b1, "R7", "overflow on held slot", int'(ovf_flag), 1);
            cmp_mem("R7");
            pulse_clr();
         end
         host_release(base);
         send(4, 17);
         settle();
         cmp_mem("R7");
         chk(ovf_flag === movf, "R7", "ovf after refill", int'(ovf_flag), int'(movf));
      end

      // R8 reserved sources
      do_reset(2, 3);
      send(6, 1);
      send(7, 2);
      settle();
      chk(rd_cnt == 0 && wr_cnt == 0, "R8", "accesses for reserved", rd_cnt + wr_cnt, 0);
      chk(ovf_flag === 1'b0, "R8", "ovf for reserved", int'(ovf_flag), 0);
      chk(ev_ready === 1'b1, "R8", "ready after reserved", int'(ev_ready), 1);
      send(1, 5);
      settle();
      chk(ram[2] == word_of(1, 5), "R8", "pointer untouched", int'(ram[2]), int'(word_of(1, 5)));
      cmp_mem("R8");

      // R9 and R10 summaries
      chk(saw_not_ready == 1, "R9", "backpressure seen", int'(saw_not_ready), 1);
      chk(both_seen == 1'b0, "R10", "rd and wr together", int'(both_seen), 0);

      report();
   end

endmodule